// File: doc/BRIEF.md
# Saturating Bipolar Violation Counter

This block keeps a running tally of line-code bipolar violations flagged by a T1 receive decoder. Each cycle the decoder may raise a violation strobe. Alongside it comes a flag that says whether that violation is part of a recognised zero-substitution word. When the substitution mode is switched on, those flagged violations are left out of the tally. All other violations move the count up by one.

The count climbs from whatever value the host last wrote and stops at its maximum (255 for the default 8-bit width). It never wraps. Once the count sits at the maximum, every further counted violation raises a one-cycle interrupt pulse, provided the interrupt enable is set. The host can therefore set an alarm threshold: it presets the counter to a value some distance below the maximum. The count is visible on a read port at all times, and reading it has no side effects. The block has no resynchronisation input, so framer resync never pauses counting.

Top module: `bpv_tally`

## Requirements
- R1: After reset the count output is 0 and the interrupt output is low.
- R2: A counted violation, with the count below 255 and no host write, raises the count by exactly 1 on the next clock edge.
- R3: When the count is 255, counted violations leave it at 255; it never wraps to 0.
- R4: A counted violation that arrives while the count is already 255 drives the interrupt output high for exactly the following cycle if the interrupt enable is 1, and leaves it low if the enable is 0.
- R5: The interrupt output is high only in the cycle after a counted violation that found the count at 255 with the enable set. In every other cycle it is low, including the cycle after the violation that takes the count from 254 to 255.
- R6: A host write loads the write data into the count on the next clock edge. If a violation strobe arrives in the same cycle as the write, it is discarded: it neither changes the count nor raises the interrupt.
- R7: When substitution mode is 1, a violation whose substitution flag is 1 neither changes the count nor raises the interrupt. When substitution mode is 0, the flag is ignored and the violation is counted.
- R8: With no violation strobe and no host write, the count holds its value, and the read port always shows the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| viol_stb | input | 1 | One-cycle strobe per detected bipolar violation |
| viol_in_subst | input | 1 | The strobed violation is part of a zero-substitution word |
| subst_mode_en | input | 1 | Substitution mode on; flagged violations are skipped |
| irq_en | input | 1 | Interrupt enable for events seen at saturation |
| host_wr | input | 1 | Host write strobe for presetting the count |
| host_wdata | input | CNT_W | Preset value |
| count_rd | output | CNT_W | Current count |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong internal count shows up on the read port one cycle after the event that caused it, because the count register drives the port directly. A bad saturation flag shows up in one of two ways: the count wraps from 255 to 0, or irq pulses at the wrong time. Either is seen in the cycle after the first violation at or near the top of the range. The bench compares both outputs every cycle against its own model. It uses presets close to 255 so that these boundary cases come up often.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  // A violation counts unless substitution mode is on and it lies in a substitution word.
  function automatic logic evt_counts(input logic stb, input logic in_word, input logic mode_on);
    return stb & ~(mode_on & in_word);
  endfunction
endpackage

// File: rtl/bpv_qualify.sv
module bpv_qualify
  import bpv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic viol_stb,
  input  logic viol_in_subst,
  input  logic subst_mode_en,
  input  logic host_wr,
  output logic evt_ok
);
  // A host write in the same cycle discards the violation.
  assign evt_ok = evt_counts(viol_stb, viol_in_subst, subst_mode_en) & ~host_wr;

  AST_SUBST_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (subst_mode_en && viol_in_subst) |-> !evt_ok); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |-> !evt_ok); // R6
endmodule

// File: rtl/bpv_sat_counter.sv
module bpv_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_ok,
  input  logic             host_wr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] count,
  output logic             at_top
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == TOP) ? v : v + CNT_W'(1);
  endfunction

  assign at_top = (count == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (host_wr) count <= host_wdata;
    else if (evt_ok)  count <= sat_inc(count);
  end

  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && !host_wr && !at_top) |=> count == $past(count) + CNT_W'(1)); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !host_wr) |=> at_top); // R3
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> count == $past(host_wdata)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_ok && !host_wr) |=> $stable(count)); // R8
endmodule

// File: rtl/bpv_irq_gen.sv
module bpv_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_ok,
  input  logic at_top,
  input  logic irq_en,
  output logic irq
);
  logic sat_evt;
  assign sat_evt = evt_ok & at_top;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= sat_evt & irq_en;
  end

  AST_IRQ_ON_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_evt && irq_en) |=> irq); // R4
  AST_IRQ_ONLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_evt && irq_en) |=> !irq); // R5
endmodule

// File: rtl/bpv_tally.sv
module bpv_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             viol_stb,
  input  logic             viol_in_subst,
  input  logic             subst_mode_en,
  input  logic             irq_en,
  input  logic             host_wr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] count_rd,
  output logic             irq
);
  logic evt_ok;
  logic at_top;

  bpv_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .viol_stb(viol_stb), .viol_in_subst(viol_in_subst),
    .subst_mode_en(subst_mode_en), .host_wr(host_wr), .evt_ok(evt_ok)
  );

  bpv_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt_ok(evt_ok), .host_wr(host_wr),
    .host_wdata(host_wdata), .count(count_rd), .at_top(at_top)
  );

  bpv_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .evt_ok(evt_ok), .at_top(at_top),
    .irq_en(irq_en), .irq(irq)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (count_rd == '0 && !irq)); // R1
endmodule

// File: tb/tb_bpv_tally.sv
module tb_bpv_tally;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic viol_stb = 0, viol_in_subst = 0, subst_mode_en = 0, irq_en = 0, host_wr = 0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] count_rd;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_cnt;
  logic m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpv_tally #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .viol_stb(viol_stb), .viol_in_subst(viol_in_subst),
    .subst_mode_en(subst_mode_en), .irq_en(irq_en), .host_wr(host_wr),
    .host_wdata(host_wdata), .count_rd(count_rd), .irq(irq)
  );

  // Independent model: which violations count, and what happens at the top of the range.
  function automatic logic counted(input logic s, input logic f, input logic m, input logic w);
    if (w || !s) return 1'b0;
    if (m && f) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic cnt_it,
                                            input logic w, input logic [W-1:0] d);
    if (w) return d;
    if (cnt_it && c != 8'd255) return c + 8'd1;
    return c;
  endfunction

  task automatic check(input string req, input logic [W-1:0] ec, input logic ei);
    checks++;
    if (count_rd !== ec || irq !== ei) begin
      errors++;
      $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b", req, count_rd, irq, ec, ei);
    end
  endtask

  // Drive one cycle at negedge, advance the model, check at the next negedge.
  task automatic step(input string req, input logic s, input logic f, input logic m,
                      input logic e, input logic w, input logic [W-1:0] d);
    logic c;
    viol_stb = s; viol_in_subst = f; subst_mode_en = m; irq_en = e; host_wr = w; host_wdata = d;
    c = counted(s, f, m, w);
    m_irq = c && (m_cnt == 8'd255) && e;
    m_cnt = next_cnt(m_cnt, c, w, d);
    @(negedge clk);
    check(req, m_cnt, m_irq);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: count=%0d irq=%0b expected completion", count_rd, irq);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = '0; m_irq = 1'b0;
    check("R1", 8'd0, 1'b0);
    step("R8", 0, 0, 0, 1, 0, 8'd0);
    step("R2", 1, 0, 0, 1, 0, 8'd0);
    step("R2", 1, 1, 0, 1, 0, 8'd0);   // R7 flag ignored when mode off
    step("R7", 1, 1, 1, 1, 0, 8'd0);   // skipped when mode on
    step("R6", 0, 0, 0, 1, 1, 8'd253);
    step("R2", 1, 0, 0, 1, 0, 8'd0);   // 254
    step("R5", 1, 0, 0, 1, 0, 8'd0);   // reaches 255, no irq yet
    step("R4", 1, 0, 0, 1, 0, 8'd0);   // irq pulse, stays 255
    step("R3", 1, 0, 0, 1, 0, 8'd0);
    step("R5", 0, 0, 0, 1, 0, 8'd0);   // pulse ends
    step("R4", 1, 0, 0, 0, 0, 8'd0);   // masked
    step("R7", 1, 1, 1, 1, 0, 8'd0);   // skipped word at top: no irq
    step("R6", 1, 0, 0, 1, 1, 8'd10);  // write wins, no irq
    step("R6", 1, 0, 0, 1, 1, 8'd255);
    step("R6", 1, 0, 0, 1, 1, 8'd0);   // strobe with write at top discarded
    step("R8", 0, 0, 0, 1, 0, 8'd0);
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [W-1:0] d;
      w = ($urandom % 24) == 0;
      d = ($urandom % 2) ? 8'(250 + ($urandom % 6)) : 8'($urandom);
      step("R2", ($urandom % 3) != 0, ($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0, w, d);
    end
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = '0; m_irq = 1'b0;
    check("R1", 8'd0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule